// File: doc/BRIEF.md
# Byte-Lane Block-RAM Bus Slave

This block is a classic-cycle Wishbone slave in front of an on-chip, single-port, synchronous word memory. It is intended for a small bit-serial RISC-V processor. That kind of master is careless about its side signals: it leaves byte select and write data at arbitrary values during reads and idle cycles, and it releases its data bus in the same cycle that it drops `cyc`. The slave therefore qualifies every side effect with `cyc`, `stb` and `we` before acting on it.

Each accepted request gets an acknowledge one clock later, and that acknowledge lasts a single cycle. A read returns the registered word in the acknowledge cycle. A write updates only the byte lanes whose select bit is set. The word index comes from the address bits above the byte offset, and the memory depth is a parameter.

Top module: `wbram_slave`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `wb_ack` is 0 and `wb_dat_r` is 0.
- R2: When `wb_cyc` and `wb_stb` are sampled high with `wb_ack` low, `wb_ack` is high in the next cycle for exactly one cycle. A master that keeps `wb_cyc` and `wb_stb` high continuously sees `wb_ack` alternate 1, 0, 1, 0.
- R3: `wb_ack` is never high in a cycle where `wb_cyc` is low, including when the master drops `wb_cyc` in the acknowledge cycle itself.
- R4: On a write, `wb_sel[i]` set replaces bits 8*i+7..8*i of the addressed word with the same bits of `wb_dat_w`. Bytes whose select bit is clear keep their old value.
- R5: On a read, `wb_dat_r` carries the addressed word during the cycle in which `wb_ack` is high.
- R6: During a read, `wb_sel` and `wb_dat_w` have no effect on the memory, whatever their values.
- R7: No memory byte changes in any cycle where `wb_cyc` or `wb_stb` is low, whatever the values of `wb_we`, `wb_sel` and `wb_dat_w`.
- R8: A request writes exactly once, at the edge that raises `wb_ack`. A change to `wb_dat_w` during the acknowledge cycle is not stored.
- R9: Address bits 1..0 are ignored. The word index is address bits above bit 1, taken modulo `DEPTH`, so address `4*DEPTH + a` refers to the same word as `a`.
- R10: In the acknowledge cycle of a write, `wb_dat_r` holds the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 for a write, 0 for a read |
| wb_adr | input | 32 | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_sel | input | 4 | Byte-lane select, used on writes only |
| wb_dat_r | output | 32 | Read data, valid while `wb_ack` is high |
| wb_ack | output | 1 | Transfer acknowledge |

## Verification
A stuck or doubled acknowledge register shows up at the ports on the very next request. There `wb_ack` either stays high for two cycles, or a second write lands on the word. A lane enable that stays active, or one driven from a read's select value, cannot be seen in the cycle it does its damage. It appears as a wrong byte the next time that word is read. For this reason every stray-write stimulus in the bench is followed at once by a read-back of the affected word. The read-first value returned with a write acknowledge exposes a wrong word index within one transfer.

// File: rtl/wbram_pkg.sv
// Package: shared definitions for the byte-lane block-RAM bus slave.
// Assumes 8-bit byte lanes; the data width is a multiple of 8.
package wbram_pkg;

    localparam int BYTE_W = 8;

    // Kind of transfer the slave acts on in the current cycle.
    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_kind_t;

    // Classify the bus request; a request already being acknowledged is idle.
    function automatic xfer_kind_t classify(
        input logic cyc,
        input logic stb,
        input logic we,
        input logic busy
    );
        if (!(cyc && stb) || busy) begin
            return XFER_IDLE;
        end
        return we ? XFER_WRITE : XFER_READ;
    endfunction

endpackage

// File: rtl/wbram_ctrl.sv
// Module: wbram_ctrl
// Decodes bus requests into an acknowledge and per-lane write enables.
// Assumes: a classic-cycle master that holds cyc/stb until it sees ack.
// Byte select is trusted only while a write is actually accepted.
module wbram_ctrl
    import wbram_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    output logic             ack,
    output logic             rd_en,
    output logic [SEL_W-1:0] lane_we
);

    logic       ack_q;
    xfer_kind_t kind;

    // Classify the current cycle; an outstanding ack blocks a second action.
    always_comb begin
        kind = classify(cyc, stb, we, ack_q);
    end

    // Register the acknowledge: one pulse per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= (kind != XFER_IDLE);
        end
    end

    // Qualify ack with cyc so an aborted cycle never sees a late ack.
    always_comb begin
        ack = ack_q && cyc;
    end

    // Capture read data for every accepted transfer (read-first on writes).
    always_comb begin
        rd_en = (kind != XFER_IDLE);
    end

    // Lane write enables: select honoured only on an accepted write.
    always_comb begin
        lane_we = (kind == XFER_WRITE) ? sel : '0;
    end

endmodule

// File: rtl/wbram_mem.sv
// Module: wbram_mem
// Single-port synchronous memory split into independent byte banks.
// Assumes: index already reduced to the memory depth. Read is registered
// and read-first: a write in the same cycle returns the old contents.
// Contents are not reset; only the output register is.
module wbram_mem
    import wbram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int SEL_W = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DATA_W = SEL_W * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  lane_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < SEL_W; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        // Store this lane's byte when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                bank[idx] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        // Register this lane's byte for the acknowledge cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*BYTE_W +: BYTE_W] <= '0;
            end else if (rd_en) begin
                rdata[g*BYTE_W +: BYTE_W] <= bank[idx];
            end
        end
    end

endmodule

// File: rtl/wbram_slave.sv
// Module: wbram_slave (top)
// Classic-cycle Wishbone slave over a byte-lane block RAM.
// Assumes: a master that may drive arbitrary sel/data outside writes and
// drops its data together with cyc. Word index = adr above the byte offset,
// modulo DEPTH.
module wbram_slave
    import wbram_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 256,
    parameter int SEL_W  = 4,
    localparam int DATA_W   = SEL_W * BYTE_W,
    localparam int WORD_LSB = (SEL_W > 1) ? $clog2(SEL_W) : 0,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0] wb_dat_w,
    input  logic [SEL_W-1:0]  wb_sel,
    output logic [DATA_W-1:0] wb_dat_r,
    output logic              wb_ack
);

    logic [IDX_W-1:0] word_idx;
    logic [SEL_W-1:0] lane_we;
    logic             rd_en;
    logic             unused_adr;

    // Word index from the address bits above the byte offset.
    always_comb begin
        word_idx = wb_adr[WORD_LSB +: IDX_W];
    end

    // Fold the ignored address bits together so they are accounted for.
    always_comb begin
        unused_adr = ^wb_adr;
    end

    wbram_ctrl #(
        .SEL_W (SEL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (wb_cyc),
        .stb     (wb_stb),
        .we      (wb_we),
        .sel     (wb_sel),
        .ack     (wb_ack),
        .rd_en   (rd_en),
        .lane_we (lane_we)
    );

    wbram_mem #(
        .DEPTH (DEPTH),
        .SEL_W (SEL_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .lane_we (lane_we),
        .idx     (word_idx),
        .wdata   (wb_dat_w),
        .rdata   (wb_dat_r)
    );

endmodule

// File: rtl/wbram_slave_chk.sv
// Module: wbram_slave_chk
// Protocol checker for wbram_slave, attached by bind below. Observes the
// bus ports and the lane enables passed from the controller to the memory.
module wbram_slave_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_we,
    input logic             wb_ack,
    input logic [SEL_W-1:0] lane_we
);

    // R2: an acknowledge lasts one cycle.
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    // R2: a fresh request is acknowledged next cycle unless cyc is dropped.
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_stb && !wb_ack) |=> (wb_ack || !wb_cyc));

    // R3: no acknowledge outside a bus cycle.
    assert_no_ack_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_cyc |-> !wb_ack);

    // R7: a lane enable requires a live write request.
    assert_we_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> (wb_cyc && wb_stb && wb_we));

    // R6: reads never enable a lane, whatever the select.
    assert_read_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_we |-> (lane_we == '0));

    // R8: no write in the acknowledge cycle.
    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> (lane_we == '0));

endmodule

bind wbram_slave wbram_slave_chk #(
    .SEL_W (SEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_cyc  (wb_cyc),
    .wb_stb  (wb_stb),
    .wb_we   (wb_we),
    .wb_ack  (wb_ack),
    .lane_we (lane_we)
);

// File: tb/test_wbram_slave.sv
// Bench for wbram_slave: a vector table walked by one loop, then directed
// tests for reset, ack timing, aborts, stray writes and aliasing.
module test_wbram_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0;
    logic        wb_stb = 1'b0;
    logic        wb_we = 1'b0;
    logic [31:0] wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic [3:0]  wb_sel = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wbram_slave i_wbram_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_w (wb_dat_w),
        .wb_sel   (wb_sel),
        .wb_dat_r (wb_dat_r),
        .wb_ack   (wb_ack)
    );

    typedef struct packed {
        logic        chk;
        logic        we;
        logic [31:0] adr;
        logic [3:0]  sel;
        logic [31:0] dat;
        logic [31:0] exp;
    } vec_t;

    // Writes expect the old word (R10); reads expect the stored word (R5).
    localparam vec_t VECS [11] = '{
        '{1'b0, 1'b1, 32'h00, 4'hF, 32'h11223344, 32'h0},
        '{1'b0, 1'b1, 32'h04, 4'hF, 32'hAABBCCDD, 32'h0},
        '{1'b0, 1'b1, 32'h08, 4'hF, 32'h01020304, 32'h0},
        '{1'b1, 1'b0, 32'h00, 4'h0, 32'h5A5A5A5A, 32'h11223344},
        '{1'b1, 1'b1, 32'h00, 4'h5, 32'hEEFF9988, 32'h11223344},
        '{1'b1, 1'b0, 32'h00, 4'hA, 32'hFFFFFFFF, 32'h11FF3388},
        '{1'b1, 1'b1, 32'h04, 4'h8, 32'h55000000, 32'hAABBCCDD},
        '{1'b1, 1'b0, 32'h07, 4'h3, 32'h12121212, 32'h55BBCCDD},
        '{1'b1, 1'b1, 32'h08, 4'h2, 32'h0000EE00, 32'h01020304},
        '{1'b1, 1'b0, 32'h08, 4'hF, 32'hFFFF0000, 32'h0102EE04},
        '{1'b1, 1'b0, 32'h04, 4'hC, 32'h00000000, 32'h55BBCCDD}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer: request, sample in the ack cycle, then idle with garbage.
    task automatic xfer(input logic we, input logic [31:0] adr, input logic [3:0] sel,
                        input logic [31:0] dat, output logic [31:0] rd);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we;
        wb_adr = adr; wb_sel = sel; wb_dat_w = dat;
        @(negedge clk);
        check("R2 ack in cycle after request", {31'b0, wb_ack}, 32'd1);
        rd = wb_dat_r;
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b1;
        wb_sel = 4'hF; wb_dat_w = 32'hDEADBEEF;
        @(negedge clk);
        check("R2 ack single cycle", {31'b0, wb_ack}, 32'd0);
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected<=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [3:0]  ack_seen;

        // R1: reset state, with garbage on the data side.
        wb_sel = 4'hF; wb_dat_w = 32'hFFFFFFFF; wb_we = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ack during reset", {31'b0, wb_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", {31'b0, wb_ack}, 32'd0);
        check("R1 dat_r after reset", wb_dat_r, 32'd0);

        // Table walk: R4 lane writes, R5 reads, R6 read select, R9 low bits, R10.
        for (int i = 0; i < 11; i++) begin
            xfer(VECS[i].we, VECS[i].adr, VECS[i].sel, VECS[i].dat, rd);
            if (VECS[i].chk) begin
                check(VECS[i].we ? "R10 old word on write ack" : "R4 R5 R6 read word",
                      rd, VECS[i].exp);
            end
        end

        // R2: continuous request gives ack 1,0,1,0.
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = 32'h0; wb_sel = 4'hF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ack_seen[k] = wb_ack;
            if (k == 0) check("R5 data with held request", wb_dat_r, 32'h11FF3388);
        end
        check("R2 alternating ack", {28'b0, ack_seen}, 32'h5);
        wb_cyc = 1'b0; wb_stb = 1'b0;
        @(negedge clk);

        // R3: master drops cyc in the ack cycle.
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = 32'h4;
        @(negedge clk);
        check("R3 ack before abort", {31'b0, wb_ack}, 32'd1);
        wb_cyc = 1'b0; wb_stb = 1'b0;
        #1;
        check("R3 ack gone with cyc", {31'b0, wb_ack}, 32'd0);
        @(negedge clk);
        check("R3 ack stays low", {31'b0, wb_ack}, 32'd0);

        // R7: write-looking garbage with cyc or stb low must not store.
        wb_cyc = 1'b1; wb_stb = 1'b0; wb_we = 1'b1; wb_sel = 4'hF;
        wb_adr = 32'h0; wb_dat_w = 32'hDEADBEEF;
        repeat (2) @(negedge clk);
        check("R7 no ack with stb low", {31'b0, wb_ack}, 32'd0);
        wb_cyc = 1'b0; wb_stb = 1'b1;
        repeat (2) @(negedge clk);
        wb_stb = 1'b0;
        xfer(1'b0, 32'h0, 4'h0, 32'h0, rd);
        check("R7 word untouched by stray write", rd, 32'h11FF3388);

        // R8: data changed during the ack cycle is not stored.
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = 32'h8;
        wb_sel = 4'hF; wb_dat_w = 32'h12345678;
        @(negedge clk);
        wb_dat_w = 32'h0BADF00D;
        @(negedge clk);
        wb_cyc = 1'b0; wb_stb = 1'b0;
        xfer(1'b0, 32'h8, 4'hF, 32'h0, rd);
        check("R8 single write per request", rd, 32'h12345678);

        // R9: address beyond the depth aliases modulo DEPTH (256 words).
        xfer(1'b1, 32'h40C, 4'hF, 32'hCAFEF00D, rd);
        xfer(1'b0, 32'h00E, 4'h0, 32'h0, rd);
        check("R9 aliased word", rd, 32'hCAFEF00D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule